// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the datapath half of a processor that spreads each instruction over several clock cycles. One memory port serves both instruction fetch and data access, and one ALU handles the program-counter increment, the branch-target sum and the data arithmetic. Holding registers keep values from one cycle to the next: an instruction register, a memory data register, two operand registers and an ALU result register. A separate controller, which is not part of this block, drives the select and write-enable inputs on every cycle. It reads back the opcode field and the ALU zero flag.

The memory sits outside the block. The datapath presents an address, write data and read/write strobes, and it takes the read word back combinationally in the same cycle. Instructions are 32 bits wide with fixed field positions. The register file has a hard-wired zero register.

Top module: `mcdp_datapath`

## Requirements
- R1: An active-low asynchronous reset clears the PC, all holding registers and every register-file entry. After reset, with all controls low, the memory address and the opcode output are 0 and the zero flag is 1.
- R2: The memory address is the PC when `iord`=0 and the ALU result register when `iord`=1.
- R3: The instruction register loads the memory read word at a clock edge only when `ir_write`=1, and holds otherwise. `opcode` shows its bits 31:26.
- R4: ALU input A is the PC when `alu_src_a`=0 and operand register A when it is 1. ALU input B is selected by `alu_src_b` as follows: 00 gives operand register B, 01 gives the constant 4, 10 gives the sign-extended bits 15:0 of the instruction, and 11 gives that value shifted left by two.
- R5: `alu_op` 00 adds and 01 subtracts (A minus B). When bit 1 is set, funct (instruction bits 5:0) picks the operation: 0x20/0x21 add, 0x22/0x23 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than, and any other code adds. `zero` is 1 exactly when the ALU result is all zeros.
- R6: The memory data, operand A/B and ALU result registers load on every clock edge with no enable. Operands A and B come from the registers named by instruction bits 25:21 and 20:16.
- R7: Register 0 always reads as zero, and a write to it is discarded.
- R8: The PC loads when `pc_write`=1, or when `pc_write_cond`=1 and `zero`=1. The new value is selected by `pc_source`: 00 gives the ALU result, 01 gives the ALU result register, 10 gives {PC[31:28], instruction[25:0], 00}, and 11 keeps the PC unchanged.
- R9: A register write with `reg_write`=1 goes to the register in instruction bits 15:11 when `reg_dst`=1 and to bits 20:16 when it is 0. The data is the ALU result register when `mem_to_reg`=0 and the memory data register when it is 1. `mem_wdata` is operand register B, and `mem_rd`/`mem_wr` follow `mem_read`/`mem_write`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_write | input | 1 | Unconditional PC load |
| pc_write_cond | input | 1 | PC load when the zero flag is set |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_read | input | 1 | Memory read request |
| mem_write | input | 1 | Memory write request |
| ir_write | input | 1 | Instruction register load enable |
| mem_to_reg | input | 1 | Register write data select |
| reg_dst | input | 1 | Destination register field select |
| reg_write | input | 1 | Register file write enable |
| alu_src_a | input | 1 | ALU A select |
| alu_src_b | input | 2 | ALU B select |
| alu_op | input | 2 | ALU operation class |
| pc_source | input | 2 | Next-PC select |
| mem_rdata | input | XLEN | Memory read word |
| mem_addr | output | XLEN | Memory byte address |
| mem_wdata | output | XLEN | Memory write word |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction register bits 31:26 |
| zero | output | 1 | ALU result is zero |

## Verification
The bench acts as the controller. It runs loads, stores, register operations, branches and a jump against a small memory model. A queue scoreboard checks the address and data of every store. The bench covers a branch that is taken and one that is not; a design that reads `zero` the wrong way round or ignores `pc_write_cond` would fetch from the wrong address on the next fetch. A store with a negative offset catches zero-extension of the immediate, and the branch target catches a missing shift by two. A write to register 0 followed by a store of it catches a zero register that can be overwritten. Set-less-than on a negative operand catches an unsigned compare, and a store of a never-written register checks the register-file reset.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

  typedef enum logic [1:0] {
    OPB_REG    = 2'b00,
    OPB_FOUR   = 2'b01,
    OPB_IMM    = 2'b10,
    OPB_IMM_SH = 2'b11
  } opb_sel_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FN_LO = 2'b10,
    AOP_FN_HI = 2'b11
  } aop_e;

  typedef enum logic [1:0] {
    NPC_ALU    = 2'b00,
    NPC_ALUOUT = 2'b01,
    NPC_JUMP   = 2'b10,
    NPC_HOLD   = 2'b11
  } npc_sel_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_SLT = 3'd4
  } alu_fn_e;

  localparam logic [5:0] FC_ADD  = 6'h20;
  localparam logic [5:0] FC_ADDU = 6'h21;
  localparam logic [5:0] FC_SUB  = 6'h22;
  localparam logic [5:0] FC_SUBU = 6'h23;
  localparam logic [5:0] FC_AND  = 6'h24;
  localparam logic [5:0] FC_OR   = 6'h25;
  localparam logic [5:0] FC_SLT  = 6'h2A;

  localparam int unsigned IMM_W  = 16;
  localparam int unsigned JFLD_W = 26;

endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);

  logic [XLEN-1:0] regs_q [NREG];
  logic [XLEN-1:0] regs_d [NREG];

  // next state: entry 0 never takes a write
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
    end
    if (we && (wa != '0)) begin
      regs_d[wa] = wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        regs_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        regs_q[i] <= regs_d[i];
      end
    end
  end

  assign rd1 = regs_q[ra1];
  assign rd2 = regs_q[ra2];

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> (rd1 == '0)); // R7

  AST_R0_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa == '0) && (ra2 == '0)) |=> (rd2 == '0) || ($past(ra2) != ra2)); // R7

endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [1:0]      alu_op,
  input  logic [5:0]      funct,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  alu_fn_e fn;
  logic    lt_signed;

  // operation decode: class first, funct only when the class asks for it
  always_comb begin
    fn = FN_ADD;
    case (aop_e'(alu_op))
      AOP_ADD: fn = FN_ADD;
      AOP_SUB: fn = FN_SUB;
      default: begin
        case (funct)
          FC_ADD, FC_ADDU: fn = FN_ADD;
          FC_SUB, FC_SUBU: fn = FN_SUB;
          FC_AND:          fn = FN_AND;
          FC_OR:           fn = FN_OR;
          FC_SLT:          fn = FN_SLT;
          default:         fn = FN_ADD;
        endcase
      end
    endcase
  end

  assign lt_signed = ($signed(opa) < $signed(opb));

  always_comb begin
    case (fn)
      FN_ADD:  result = opa + opb;
      FN_SUB:  result = opa - opb;
      FN_AND:  result = opa & opb;
      FN_OR:   result = opa | opb;
      FN_SLT:  result = {{(XLEN-1){1'b0}}, lt_signed};
      default: result = opa + opb;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/mcdp_pc.sv
module mcdp_pc
  import mcdp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_write,
  input  logic              pc_write_cond,
  input  logic              zero,
  input  logic [1:0]        pc_source,
  input  logic [XLEN-1:0]   alu_result,
  input  logic [XLEN-1:0]   alu_out,
  input  logic [JFLD_W-1:0] jfield,
  output logic [XLEN-1:0]   pc_q
);

  localparam int unsigned HI_W = XLEN - JFLD_W - 2;

  logic            pc_en;
  logic [XLEN-1:0] pc_sel;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] jump_tgt;

  assign jump_tgt = {pc_q[XLEN-1 -: HI_W], jfield, 2'b00};
  assign pc_en    = pc_write | (pc_write_cond & zero);

  always_comb begin
    case (npc_sel_e'(pc_source))
      NPC_ALU:    pc_sel = alu_result;
      NPC_ALUOUT: pc_sel = alu_out;
      NPC_JUMP:   pc_sel = jump_tgt;
      default:    pc_sel = pc_q;
    endcase
  end

  always_comb begin
    pc_d = pc_q;
    if (pc_en) begin
      pc_d = pc_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_write || (pc_write_cond && zero)) |=> $stable(pc_q)); // R8

  AST_PC_JUMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_write && (pc_source == 2'b10)) |=> (pc_q[JFLD_W+1:0] == {$past(jfield), 2'b00})); // R8

  AST_PC_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_write && pc_write_cond && zero && (pc_source == 2'b01)) |=> (pc_q == $past(alu_out))); // R8

endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
  import mcdp_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_write,
  input  logic            pc_write_cond,
  input  logic            iord,
  input  logic            mem_read,
  input  logic            mem_write,
  input  logic            ir_write,
  input  logic            mem_to_reg,
  input  logic            reg_dst,
  input  logic            reg_write,
  input  logic            alu_src_a,
  input  logic [1:0]      alu_src_b,
  input  logic [1:0]      alu_op,
  input  logic [1:0]      pc_source,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [5:0]      opcode,
  output logic            zero
);

  localparam int unsigned AW     = $clog2(NREG);
  localparam int unsigned RS_LSB = 21;
  localparam int unsigned RT_LSB = 16;
  localparam int unsigned RD_LSB = 11;

  logic [XLEN-1:0] ir_q, ir_d;
  logic [XLEN-1:0] mdr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] rf_rd1, rf_rd2;
  logic [XLEN-1:0] alu_a, alu_b, alu_res;
  logic [XLEN-1:0] imm_sx, imm_sx_sh;
  logic [AW-1:0]   rs_idx, rt_idx, rd_idx, wr_idx;
  logic [XLEN-1:0] wr_data;

  // instruction fields
  assign rs_idx    = ir_q[RS_LSB +: AW];
  assign rt_idx    = ir_q[RT_LSB +: AW];
  assign rd_idx    = ir_q[RD_LSB +: AW];
  assign opcode    = ir_q[31:26];
  assign imm_sx    = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sx_sh = {imm_sx[XLEN-3:0], 2'b00};

  // holding registers: IR gated, the rest load every edge
  always_comb begin
    ir_d = ir_q;
    if (ir_write) begin
      ir_d = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      ir_q     <= ir_d;
      mdr_q    <= mem_rdata;
      a_q      <= rf_rd1;
      b_q      <= rf_rd2;
      aluout_q <= alu_res;
    end
  end

  // memory side
  assign mem_addr  = iord ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = mem_read;
  assign mem_wr    = mem_write;

  // register write path
  assign wr_idx  = reg_dst ? rd_idx : rt_idx;
  assign wr_data = mem_to_reg ? mdr_q : aluout_q;

  mcdp_regfile #(
    .XLEN (XLEN),
    .NREG (NREG)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (rs_idx),
    .ra2   (rt_idx),
    .we    (reg_write),
    .wa    (wr_idx),
    .wd    (wr_data),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2)
  );

  // ALU operand selection
  assign alu_a = alu_src_a ? a_q : pc_q;

  always_comb begin
    case (opb_sel_e'(alu_src_b))
      OPB_REG:  alu_b = b_q;
      OPB_FOUR: alu_b = XLEN'(4);
      OPB_IMM:  alu_b = imm_sx;
      default:  alu_b = imm_sx_sh;
    endcase
  end

  mcdp_alu #(
    .XLEN (XLEN)
  ) u_alu (
    .opa    (alu_a),
    .opb    (alu_b),
    .alu_op (alu_op),
    .funct  (ir_q[5:0]),
    .result (alu_res),
    .zero   (zero)
  );

  mcdp_pc #(
    .XLEN (XLEN)
  ) u_pc (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_write      (pc_write),
    .pc_write_cond (pc_write_cond),
    .zero          (zero),
    .pc_source     (pc_source),
    .alu_result    (alu_res),
    .alu_out       (aluout_q),
    .jfield        (ir_q[JFLD_W-1:0]),
    .pc_q          (pc_q)
  );

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_write |=> $stable(ir_q)); // R3

  AST_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ir_write |=> (ir_q == $past(mem_rdata))); // R3

  AST_MDR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (mdr_q == $past(mem_rdata))); // R6

  AST_SUB_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((alu_op == 2'b01) && (alu_a == alu_b)) |-> zero); // R5

endmodule

// File: tb/mcdp_datapath_tb_top.sv
module mcdp_datapath_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } wr_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pc_write, pc_write_cond, iord, mem_read, mem_write, ir_write;
  logic        mem_to_reg, reg_dst, reg_write, alu_src_a;
  logic [1:0]  alu_src_b, alu_op, pc_source;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_rd, mem_wr, zero;
  logic [5:0]  opcode;

  logic [31:0] mem [MEM_WORDS];
  wr_item_t    exp_q [$];
  wr_item_t    mon_item;
  logic [31:0] exp_pc;
  int          n_checks = 0;
  int          n_bad    = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:2]];

  mcdp_datapath dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_write      (pc_write),
    .pc_write_cond (pc_write_cond),
    .iord          (iord),
    .mem_read      (mem_read),
    .mem_write     (mem_write),
    .ir_write      (ir_write),
    .mem_to_reg    (mem_to_reg),
    .reg_dst       (reg_dst),
    .reg_write     (reg_write),
    .alu_src_a     (alu_src_a),
    .alu_src_b     (alu_src_b),
    .alu_op        (alu_op),
    .pc_source     (pc_source),
    .mem_rdata     (mem_rdata),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .opcode        (opcode),
    .zero          (zero)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // store monitor: pops the scoreboard on every write strobe
  always @(posedge clk) begin
    if (rst_n === 1'b1 && mem_wr === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected store", mem_addr, 32'h0);
      end else begin
        mon_item = exp_q.pop_front();
        chk(mem_addr == mon_item.addr, "R9 R2 store address", mem_addr, mon_item.addr);
        chk(mem_wdata == mon_item.data, "R9 R6 store data", mem_wdata, mon_item.data);
      end
    end
  end

  task automatic clr();
    pc_write = 0; pc_write_cond = 0; iord = 0; mem_read = 0; mem_write = 0;
    ir_write = 0; mem_to_reg = 0; reg_dst = 0; reg_write = 0; alu_src_a = 0;
    alu_src_b = 2'b00; alu_op = 2'b00; pc_source = 2'b00;
  endtask

  task automatic fetch();
    @(negedge clk); clr();
    mem_read = 1; ir_write = 1; alu_src_b = 2'b01; pc_write = 1;
    #1;
    chk(mem_addr == exp_pc, "R8 R2 fetch address", mem_addr, exp_pc);
    chk(mem_rd == 1'b1, "R9 read strobe", 32'(mem_rd), 32'h1);
    exp_pc = exp_pc + 4;
  endtask

  task automatic decode(input logic [5:0] op);
    @(negedge clk); clr();
    alu_src_b = 2'b11;
    #1;
    chk(opcode == op, "R3 opcode after fetch", 32'(opcode), 32'(op));
  endtask

  task automatic exec_addr();
    @(negedge clk); clr();
    alu_src_a = 1; alu_src_b = 2'b10;
    #1;
  endtask

  task automatic do_lw(input logic [31:0] addr_exp);
    fetch(); decode(6'h23); exec_addr();
    @(negedge clk); clr();
    iord = 1; mem_read = 1;
    #1;
    chk(mem_addr == addr_exp, "R4 R2 load address", mem_addr, addr_exp);
    @(negedge clk); clr();
    mem_to_reg = 1; reg_write = 1;
    #1;
  endtask

  task automatic do_sw(input logic [31:0] addr_exp, input logic [31:0] data_exp);
    exp_q.push_back('{addr: addr_exp, data: data_exp});
    fetch(); decode(6'h2B); exec_addr();
    @(negedge clk); clr();
    iord = 1; mem_write = 1;
    #1;
    chk(mem_wr == 1'b1, "R9 write strobe", 32'(mem_wr), 32'h1);
    chk(opcode == 6'h2B, "R3 opcode held during data access", 32'(opcode), 32'h2B);
  endtask

  task automatic do_r();
    fetch(); decode(6'h00);
    @(negedge clk); clr();
    alu_src_a = 1; alu_op = 2'b10;
    #1;
    @(negedge clk); clr();
    reg_dst = 1; reg_write = 1;
    #1;
  endtask

  task automatic do_beq(input bit zexp, input logic [31:0] target);
    fetch(); decode(6'h04);
    @(negedge clk); clr();
    alu_src_a = 1; alu_op = 2'b01; pc_write_cond = 1; pc_source = 2'b01;
    #1;
    chk(zero == zexp, "R5 compare zero flag", 32'(zero), 32'(zexp));
    if (zexp) exp_pc = target;
  endtask

  task automatic do_j(input logic [31:0] target);
    fetch(); decode(6'h02);
    @(negedge clk); clr();
    pc_write = 1; pc_source = 2'b10;
    #1;
    exp_pc = target;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog R1 act=%h exp=%h", 32'h1, 32'h0);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
    mem[0]  = enc_i(6'h23, 0, 1, 16'h0080);        // lw  r1, 0x80(r0)
    mem[1]  = enc_i(6'h23, 0, 2, 16'h0084);        // lw  r2, 0x84(r0)
    mem[2]  = enc_r(1, 2, 3, 6'h20);               // add r3 = r1 + r2
    mem[3]  = enc_i(6'h2B, 0, 3, 16'h0088);        // sw  r3
    mem[4]  = enc_r(1, 2, 4, 6'h22);               // sub r4 = r1 - r2
    mem[5]  = enc_i(6'h2B, 0, 4, 16'h008C);        // sw  r4
    mem[6]  = enc_i(6'h04, 1, 2, 16'h0005);        // beq r1,r2 not taken
    mem[7]  = enc_i(6'h04, 1, 1, 16'h0001);        // beq r1,r1 taken -> 0x24
    mem[8]  = enc_i(6'h2B, 0, 1, 16'h0090);        // skipped
    mem[9]  = {6'h02, 26'h000000C};                // j 0x30
    mem[12] = enc_r(1, 1, 0, 6'h20);               // add r0 (discarded)
    mem[13] = enc_i(6'h2B, 0, 0, 16'h0094);        // sw  r0
    mem[14] = enc_i(6'h23, 0, 6, 16'h0098);        // lw  r6
    mem[15] = enc_i(6'h2B, 6, 3, 16'hFFFC);        // sw  r3, -4(r6)
    mem[16] = enc_r(1, 2, 7, 6'h24);               // and r7
    mem[17] = enc_i(6'h2B, 0, 7, 16'h00A0);        // sw  r7
    mem[18] = enc_r(2, 1, 8, 6'h2A);               // slt r8 = r2 < r1
    mem[19] = enc_i(6'h2B, 0, 8, 16'h00A4);        // sw  r8
    mem[20] = enc_i(6'h2B, 0, 5, 16'h00A8);        // sw  r5 (never written)
    mem[32] = 32'h0000_0007;
    mem[33] = 32'hFFFF_FFFD;
    mem[38] = 32'h0000_00A0;

    clr();
    rst_n  = 1'b0;
    exp_pc = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(mem_addr == 32'h0, "R1 reset address", mem_addr, 32'h0);
    chk(opcode == 6'h00, "R1 reset opcode", 32'(opcode), 32'h0);
    chk(zero == 1'b1, "R1 R5 reset zero flag", 32'(zero), 32'h1);

    do_lw(32'h80);
    do_lw(32'h84);
    do_r();
    do_sw(32'h88, 32'h4);                    // R5 add
    do_r();
    do_sw(32'h8C, 32'hA);                    // R5 sub
    do_beq(1'b0, 32'h0);                     // R8 not taken
    do_beq(1'b1, 32'h24);                    // R4 shifted offset, R8 taken
    do_j(32'h30);                            // R8 jump
    do_r();
    do_sw(32'h94, 32'h0);                    // R7 r0 write discarded
    do_lw(32'h98);
    do_sw(32'h9C, 32'h4);                    // R4 negative sign-extended offset
    do_r();
    do_sw(32'hA0, 32'h5);                    // R5 and
    do_r();
    do_sw(32'hA4, 32'h1);                    // R5 signed slt
    do_sw(32'hA8, 32'h0);                    // R1 register file cleared
    fetch();                                 // R8 sequential PC after stores

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all stores seen", 32'(exp_q.size()), 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule